// File: doc/BRIEF.md
# Byte-to-Symbol 8b/10b Line Encoder

This block turns one byte per clock into a 10-bit DC-balanced code group following the usual 8b/10b scheme: the low five bits go through a 5b/6b sub-encoder and the high three bits through a 3b/4b sub-encoder. Each sub-block picks its polarity from the running disparity. A per-byte control select asks for a control (K) group instead of a data (D) group. Only the twelve legal control groups are honoured. Any other byte sent with the control select high raises an error flag and goes out as its data encoding.

A caller can override the disparity choice for a single group. While the force input is high, the disparity-value input picks the negative-disparity-start form or the positive-disparity-start form of that group, whatever the current running disparity. All qualifiers are sampled together with the byte they belong to. The running disparity then follows whatever was actually emitted. Output is registered, one cycle after a valid input.

Top module: `byte_symbol_encoder`

## Requirements
- R1: The output group is laid out as out_code[9:4] = 6-bit sub-block in transmit order a,b,c,d,e,i (a at bit 9) and out_code[3:0] = 4-bit sub-block f,g,h,j (f at bit 3). A data byte with bits HGF_EDCBA maps EDCBA (x) to the 6-bit part and HGF (y) to the 4-bit part, per the standard Dx.y tables.
- R2: With in_force low, the 6-bit sub-block uses its negative-start form when running disparity is negative and its positive-start form otherwise. The 4-bit sub-block makes the same choice using the disparity left after the 6-bit sub-block. Unbalanced forms are complements of each other, and so are the pairs 111000/000111 and 1100/0011.
- R3: With in_force high, in_dispval high encodes the group as if running disparity were negative, so the group has 5 or 6 ones. in_dispval low encodes it as if running disparity were positive, so the group has 4 or 5 ones.
- R4: out_rd (1 = positive) after each group is positive if the group has 6 ones, negative if it has 4 ones, and otherwise equal to the disparity the group was encoded from.
- R5: With in_ctrl high, K28.0 to K28.7, K23.7, K27.7, K29.7 and K30.7 produce the standard control groups. For example, K28.5 from negative disparity gives 0011111010 and from positive disparity gives 1100000101. out_kerr stays low for these.
- R6: With in_ctrl high and any other byte, out_kerr is high for that group and out_code is the data encoding of the byte. With in_ctrl low, out_kerr is low.
- R7: For y = 7, the alternate 4-bit form (0111 / 1000) replaces the primary form (1110 / 0001) when disparity after the 6-bit part is negative and x is 17, 18 or 20, or is positive and x is 11, 13 or 14. It is also used for every K.x.7.
- R8: A group accepted with in_vld high appears at the outputs one clock later with out_vld high. out_vld is low one clock after a cycle with in_vld low.
- R9: A cycle with in_vld low leaves out_code, out_rd and out_kerr unchanged.
- R10: Synchronous active-low reset sets running disparity negative and clears out_vld, out_kerr and out_code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_vld | input | 1 | Byte and qualifiers are valid this cycle |
| in_byte | input | 8 | Byte to encode (HGF_EDCBA) |
| in_ctrl | input | 1 | High requests a control group |
| in_force | input | 1 | High overrides running disparity for this byte |
| in_dispval | input | 1 | With in_force: high = negative-start form, low = positive-start form |
| out_vld | output | 1 | Registered group valid |
| out_code | output | 10 | Encoded group, bit 9 sent first |
| out_rd | output | 1 | Running disparity after the group, 1 = positive |
| out_kerr | output | 1 | Illegal control byte was requested |

## Verification
The cases that are hardest to reach from the ports are the data groups that switch to the alternate 4-bit form. They appear only for six x values, and only when the disparity left by the 6-bit sub-block has one particular sign. A free-running sequence hits them rarely and unevenly. The bench therefore uses the force input to encode every byte, as data and as control, from both disparity starts. This covers every alternate-form case, every illegal control request and both polarities of every control group in a fixed sweep. Long unforced random runs then check that running disparity is carried correctly from group to group.

// File: rtl/sbe_pkg.sv
`timescale 1ns/1ps
// Package: shared widths and the primary sub-block tables of the encoder.
// Assumes the standard 8b/10b code space; tables hold negative-start forms.
package sbe_pkg;
    localparam int BYTE_W = 8;
    localparam int X_W    = 5;
    localparam int Y_W    = BYTE_W - X_W;
    localparam int SB6_W  = 6;
    localparam int SB4_W  = 4;
    localparam int CODE_W = SB6_W + SB4_W;

    localparam logic [SB6_W-1:0] K28_SB6 = 6'b001111;
    localparam logic [SB4_W-1:0] ALT7_SB4 = 4'b0111;

    // Negative-start 6-bit form for data x, bit order a,b,c,d,e,i.
    function automatic logic [SB6_W-1:0] sb6_neg(input logic [X_W-1:0] x);
        case (x)
            5'd0:  sb6_neg = 6'b100111;  5'd1:  sb6_neg = 6'b011101;
            5'd2:  sb6_neg = 6'b101101;  5'd3:  sb6_neg = 6'b110001;
            5'd4:  sb6_neg = 6'b110101;  5'd5:  sb6_neg = 6'b101001;
            5'd6:  sb6_neg = 6'b011001;  5'd7:  sb6_neg = 6'b111000;
            5'd8:  sb6_neg = 6'b111001;  5'd9:  sb6_neg = 6'b100101;
            5'd10: sb6_neg = 6'b010101;  5'd11: sb6_neg = 6'b110100;
            5'd12: sb6_neg = 6'b001101;  5'd13: sb6_neg = 6'b101100;
            5'd14: sb6_neg = 6'b011100;  5'd15: sb6_neg = 6'b010111;
            5'd16: sb6_neg = 6'b011011;  5'd17: sb6_neg = 6'b100011;
            5'd18: sb6_neg = 6'b010011;  5'd19: sb6_neg = 6'b110010;
            5'd20: sb6_neg = 6'b001011;  5'd21: sb6_neg = 6'b101010;
            5'd22: sb6_neg = 6'b011010;  5'd23: sb6_neg = 6'b111010;
            5'd24: sb6_neg = 6'b110011;  5'd25: sb6_neg = 6'b100110;
            5'd26: sb6_neg = 6'b010110;  5'd27: sb6_neg = 6'b110110;
            5'd28: sb6_neg = 6'b001110;  5'd29: sb6_neg = 6'b101110;
            5'd30: sb6_neg = 6'b011110;  default: sb6_neg = 6'b101011;
        endcase
    endfunction

    // Negative-start 4-bit primary form for y, bit order f,g,h,j.
    function automatic logic [SB4_W-1:0] sb4_neg(input logic [Y_W-1:0] y);
        case (y)
            3'd0: sb4_neg = 4'b1011;  3'd1: sb4_neg = 4'b1001;
            3'd2: sb4_neg = 4'b0101;  3'd3: sb4_neg = 4'b1100;
            3'd4: sb4_neg = 4'b1101;  3'd5: sb4_neg = 4'b1010;
            3'd6: sb4_neg = 4'b0110;  default: sb4_neg = 4'b1110;
        endcase
    endfunction
endpackage

// File: rtl/sbe_k_check.sv
`timescale 1ns/1ps
// Control legality check: flags which of the twelve control groups a byte is.
// Assumes byte split x = bits [4:0], y = bits [7:5].
module sbe_k_check
    import sbe_pkg::*;
(
    input  logic [BYTE_W-1:0] byte_i,
    input  logic              ctrl_i,
    output logic              k_ok_o,
    output logic              k28_o,
    output logic              k_err_o
);
    logic [X_W-1:0] x;
    logic [Y_W-1:0] y;
    logic           legal;

    // Decide whether the requested control byte is one of the legal twelve.
    always_comb begin
        x      = byte_i[X_W-1:0];
        y      = byte_i[BYTE_W-1:X_W];
        legal  = (x == 5'd28) ||
                 ((y == 3'd7) && ((x == 5'd23) || (x == 5'd27) ||
                                  (x == 5'd29) || (x == 5'd30)));
        k_ok_o  = ctrl_i && legal;
        k28_o   = ctrl_i && (x == 5'd28);
        k_err_o = ctrl_i && !legal;
    end
endmodule

// File: rtl/sbe_enc6.sv
`timescale 1ns/1ps
// 5b/6b sub-encoder: picks the 6-bit form from the starting disparity and
// reports the disparity left behind. rd 1 = positive.
module sbe_enc6
    import sbe_pkg::*;
(
    input  logic [X_W-1:0]   x_i,
    input  logic             k28_i,
    input  logic             rd_i,
    output logic [SB6_W-1:0] sb6_o,
    output logic             rd_o
);
    logic [SB6_W-1:0] base;
    logic             swap;

    // Choose the base form and complement it from positive disparity where needed.
    always_comb begin
        base  = k28_i ? K28_SB6 : sb6_neg(x_i);
        swap  = ($countones(base) != 3) || (!k28_i && (x_i == 5'd7));
        sb6_o = (rd_i && swap) ? ~base : base;
        rd_o  = ($countones(sb6_o) == 3) ? rd_i : ($countones(sb6_o) == 4);
    end
endmodule

// File: rtl/sbe_enc4.sv
`timescale 1ns/1ps
// 3b/4b sub-encoder: primary/alternate selection for y = 7, polarity choice
// from the disparity after the 6-bit part, and control-group neutral swaps.
module sbe_enc4
    import sbe_pkg::*;
(
    input  logic [X_W-1:0]   x_i,
    input  logic [Y_W-1:0]   y_i,
    input  logic             k_i,
    input  logic             rd_i,
    output logic [SB4_W-1:0] sb4_o,
    output logic             rd_o
);
    logic             alt;
    logic             swap;
    logic             kswap;
    logic [SB4_W-1:0] base;

    // Pick the 4-bit form and its polarity, then track disparity.
    always_comb begin
        alt   = (y_i == 3'd7) &&
                (k_i ||
                 (!rd_i && ((x_i == 5'd17) || (x_i == 5'd18) || (x_i == 5'd20))) ||
                 ( rd_i && ((x_i == 5'd11) || (x_i == 5'd13) || (x_i == 5'd14))));
        base  = alt ? ALT7_SB4 : sb4_neg(y_i);
        swap  = rd_i && (($countones(base) != 2) || (y_i == 3'd3));
        kswap = k_i && !rd_i &&
                ((y_i == 3'd1) || (y_i == 3'd2) || (y_i == 3'd5) || (y_i == 3'd6));
        sb4_o = (swap || kswap) ? ~base : base;
        rd_o  = ($countones(sb4_o) == 2) ? rd_i : ($countones(sb4_o) == 3);
    end
endmodule

// File: rtl/byte_symbol_encoder.sv
`timescale 1ns/1ps
// Top: one byte per clock into a registered 10-bit group with running
// disparity tracking and a per-byte disparity override.
// Assumes all qualifiers are valid together with in_byte when in_vld is high.
module byte_symbol_encoder
    import sbe_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_vld,
    input  logic [BYTE_W-1:0] in_byte,
    input  logic              in_ctrl,
    input  logic              in_force,
    input  logic              in_dispval,
    output logic              out_vld,
    output logic [CODE_W-1:0] out_code,
    output logic              out_rd,
    output logic              out_kerr
);
    logic             k_ok, k28, k_err;
    logic             rd_start, rd_mid, rd_end;
    logic [SB6_W-1:0] sb6;
    logic [SB4_W-1:0] sb4;

    sbe_k_check u_kchk (
        .byte_i (in_byte),
        .ctrl_i (in_ctrl),
        .k_ok_o (k_ok),
        .k28_o  (k28),
        .k_err_o(k_err)
    );

    // Starting disparity: override when forced, else the tracked value.
    always_comb rd_start = in_force ? !in_dispval : out_rd;

    sbe_enc6 u_enc6 (
        .x_i  (in_byte[X_W-1:0]),
        .k28_i(k28),
        .rd_i (rd_start),
        .sb6_o(sb6),
        .rd_o (rd_mid)
    );

    sbe_enc4 u_enc4 (
        .x_i  (in_byte[X_W-1:0]),
        .y_i  (in_byte[BYTE_W-1:X_W]),
        .k_i  (k_ok),
        .rd_i (rd_mid),
        .sb4_o(sb4),
        .rd_o (rd_end)
    );

    // Output register: capture group and disparity on valid, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_vld  <= 1'b0;
            out_code <= '0;
            out_rd   <= 1'b0;
            out_kerr <= 1'b0;
        end else begin
            out_vld <= in_vld;
            if (in_vld) begin
                out_code <= {sb6, sb4};
                out_rd   <= rd_end;
                out_kerr <= k_err;
            end
        end
    end
endmodule

// File: rtl/sbe_checker.sv
`timescale 1ns/1ps
// Checker: temporal properties of the encoder, bound to the top module.
module sbe_checker
    import sbe_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              in_vld,
    input logic              in_ctrl,
    input logic              in_force,
    input logic              in_dispval,
    input logic              out_vld,
    input logic [CODE_W-1:0] out_code,
    input logic              out_rd,
    input logic              out_kerr
);
    p_latency_r8: assert property (@(posedge clk) disable iff (!rst_n)
        in_vld |=> out_vld);
    p_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !in_vld |=> !out_vld);
    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !in_vld |=> ($stable(out_code) && $stable(out_rd) && $stable(out_kerr)));
    p_balance_r4: assert property (@(posedge clk) disable iff (!rst_n)
        out_vld |-> (($countones(out_code) >= 4) && ($countones(out_code) <= 6)));
    p_rd_pos_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_vld && ($countones(out_code) == 6)) |-> out_rd);
    p_rd_neg_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_vld && ($countones(out_code) == 4)) |-> !out_rd);
    p_data_noerr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && !in_ctrl) |=> !out_kerr);
    p_force_neg_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && in_force && in_dispval) |=> ($countones(out_code) >= 5));
    p_force_pos_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && in_force && !in_dispval) |=> ($countones(out_code) <= 5));
endmodule

bind byte_symbol_encoder sbe_checker chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_vld    (in_vld),
    .in_ctrl   (in_ctrl),
    .in_force  (in_force),
    .in_dispval(in_dispval),
    .out_vld   (out_vld),
    .out_code  (out_code),
    .out_rd    (out_rd),
    .out_kerr  (out_kerr)
);

// File: tb/byte_symbol_encoder_tb_top.sv
`timescale 1ns/1ps
// Bench: swept and random stimulus against an arithmetic reference model.
module byte_symbol_encoder_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_vld = 1'b0;
    logic [7:0] in_byte = '0;
    logic       in_ctrl = 1'b0, in_force = 1'b0, in_dispval = 1'b0;
    logic       out_vld, out_rd, out_kerr;
    logic [9:0] out_code;

    int n_tests = 0;
    int n_fail  = 0;

    // model state
    logic       m_rd = 1'b0;
    logic [9:0] m_code = '0;
    logic       m_err = 1'b0;

    always #5 clk = ~clk;

    byte_symbol_encoder dut_i (
        .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_byte(in_byte),
        .in_ctrl(in_ctrl), .in_force(in_force), .in_dispval(in_dispval),
        .out_vld(out_vld), .out_code(out_code), .out_rd(out_rd), .out_kerr(out_kerr)
    );

    function automatic logic [5:0] t6(input int x);
        logic [5:0] t [32] = '{6'b100111, 6'b011101, 6'b101101, 6'b110001,
                              6'b110101, 6'b101001, 6'b011001, 6'b111000,
                              6'b111001, 6'b100101, 6'b010101, 6'b110100,
                              6'b001101, 6'b101100, 6'b011100, 6'b010111,
                              6'b011011, 6'b100011, 6'b010011, 6'b110010,
                              6'b001011, 6'b101010, 6'b011010, 6'b111010,
                              6'b110011, 6'b100110, 6'b010110, 6'b110110,
                              6'b001110, 6'b101110, 6'b011110, 6'b101011};
        return t[x];
    endfunction

    function automatic logic [3:0] t4(input int y);
        logic [3:0] t [8] = '{4'b1011, 4'b1001, 4'b0101, 4'b1100,
                             4'b1101, 4'b1010, 4'b0110, 4'b1110};
        return t[y];
    endfunction

    // Reference group from spec rules; s = starting disparity (1 = positive).
    task automatic ref_enc(input logic [7:0] b, input logic k, input logic s,
                           output logic [9:0] code, output logic rd, output logic err,
                           output string tag);
        int x = int'(b[4:0]);
        int y = int'(b[7:5]);
        logic kv = k && (x == 28 || (y == 7 && (x == 23 || x == 27 || x == 29 || x == 30)));
        logic [5:0] a6;
        logic [3:0] a4;
        logic mid;
        logic alt;
        a6 = (kv && x == 28) ? 6'b001111 : t6(x);
        if (s && ($countones(a6) != 3 || x == 7)) a6 = ~a6;
        mid = ($countones(a6) == 3) ? s : 1'b1 ^ ($countones(a6) == 2);
        alt = (y == 7) && (kv || (!mid && (x == 17 || x == 18 || x == 20)) ||
                                (mid && (x == 11 || x == 13 || x == 14)));
        a4 = alt ? 4'b0111 : t4(y);
        if (mid && ($countones(a4) != 2 || y == 3)) a4 = ~a4;
        else if (kv && !mid && (y == 1 || y == 2 || y == 5 || y == 6)) a4 = ~a4;
        code = {a6, a4};
        rd   = ($countones(code) == 5) ? s : ($countones(code) == 6);
        err  = k && !kv;
        tag  = kv ? "R5" : (err ? "R6" : (alt ? "R7" : "R2"));
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One cycle: drive at negedge, check at next negedge.
    task automatic send(input logic v, input logic [7:0] b, input logic k,
                        input logic f, input logic dv);
        logic [9:0] c;
        logic r, e, s;
        string tag;
        in_vld = v; in_byte = b; in_ctrl = k; in_force = f; in_dispval = dv;
        s = f ? !dv : m_rd;
        if (v) begin
            ref_enc(b, k, s, c, r, e, tag);
            if (f) tag = (tag == "R2") ? "R3" : tag;
            m_code = c; m_rd = r; m_err = e;
        end
        @(posedge clk);
        @(negedge clk);
        if (v) begin
            chk(out_code == m_code && out_kerr == m_err && out_rd == m_rd && out_vld,
                tag, int'({out_vld, out_kerr, out_rd, out_code}),
                int'({1'b1, m_err, m_rd, m_code}));
        end else begin
            // R9: idle cycle keeps outputs; R8: out_vld low
            chk(out_code == m_code && out_rd == m_rd && out_kerr == m_err && !out_vld,
                "R9", int'({out_vld, out_kerr, out_rd, out_code}),
                int'({1'b0, m_err, m_rd, m_code}));
        end
    endtask

    initial begin
        #2000000;
        n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] kl [12] = '{8'h1C, 8'h3C, 8'h5C, 8'h7C, 8'h9C, 8'hBC, 8'hDC, 8'hFC,
                                8'hF7, 8'hFB, 8'hFD, 8'hFE};
        repeat (3) @(negedge clk);
        // R10: reset state
        chk(out_vld == 0 && out_rd == 0 && out_kerr == 0 && out_code == 0, "R10",
            int'({out_vld, out_kerr, out_rd, out_code}), 0);
        rst_n = 1'b1;
        // R5: K28.5 from negative disparity = 0011111010, then positive = 1100000101
        send(1, 8'hBC, 1, 0, 0);
        chk(out_code == 10'b0011111010, "R5", int'(out_code), 10'b0011111010);
        send(1, 8'hBC, 1, 0, 0);
        chk(out_code == 10'b1100000101, "R5", int'(out_code), 10'b1100000101);
        // R1: D21.5 is 1010101010; D0.0 from negative is 1001110100
        send(1, 8'hB5, 0, 1, 1);
        chk(out_code == 10'b1010101010, "R1", int'(out_code), 10'b1010101010);
        send(1, 8'h00, 0, 1, 1);
        chk(out_code == 10'b1001110100, "R1", int'(out_code), 10'b1001110100);
        // R7: D17.7 from negative uses alternate form: 1000110111
        send(1, 8'hF1, 0, 1, 1);
        chk(out_code == 10'b1000110111, "R7", int'(out_code), 10'b1000110111);
        // R9/R8: idle cycles hold outputs
        send(0, 8'h55, 1, 1, 0);
        send(0, 8'hAA, 0, 0, 1);
        // R3 R6 R7: full sweep, both forced polarities, data and control
        for (int dv = 0; dv < 2; dv++)
            for (int k = 0; k < 2; k++)
                for (int b = 0; b < 256; b++)
                    send(1, 8'(b), 1'(k), 1'b1, 1'(dv));
        // R2 R4: unforced random runs with idle gaps
        for (int i = 0; i < 6000; i++) begin
            int r = int'($urandom % 16);
            if (r == 0) send(0, 8'($urandom), 1'($urandom), 0, 0);
            else if (r < 4) send(1, kl[$urandom % 12], 1, 0, 0);
            else if (r == 4) send(1, 8'($urandom), 1, 0, 0);
            else send(1, 8'($urandom), 0, 0, 0);
        end
        // R3 R4: random mix of forced and unforced groups
        for (int i = 0; i < 4000; i++) begin
            send(1, 8'($urandom), 1'(($urandom % 8) == 0), 1'($urandom), 1'($urandom));
        end
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule